// File: doc/BRIEF.md
# Split-Read 64-bit Cycle Counter

This block is a free-running 64-bit cycle counter private to one core. Software sees it through a 32-bit register bus as two half-word registers (lower half and upper half) and one control/status register. Because a 64-bit value cannot be fetched in one 32-bit access, the upper half may step between the two reads. The block does not freeze a copy of the counter to prevent this. Instead, a small tracker watches the read order and sets a status bit that says whether the last pair read belongs to one instant.

The pair is rejected if the counter carries from the lower half into the upper half during the read window. It is also rejected if the core reports a trap (interrupt or exception entry) during that window. Software reads lower, then upper, then control, and starts the whole sequence again until the status bit reads 1. The width of each half is a parameter. Reduced widths are useful for simulation.

Top module: `snapshot_counter64`

## Requirements
- R1: Reset (synchronous, active high) clears the count to zero, clears the enable and clears the status bit. After reset, control, lower and upper all read 0.
- R2: The address map is control at 0x103, lower half at 0x104 and upper half at 0x105. Any other address reads 0. In the control word, bit 0 is the enable (read/write) and bit 31 is the pair-valid status (read only). All other control bits read 0. Half registers read zero-extended.
- R3: Writing the control register loads the enable from write-data bit 0. While the enable is 1 the count rises by exactly one per clock. While it is 0 the count holds.
- R4: If an upper read follows a lower read, the status reads 1 after the upper read, provided there was no carry and no trap in the window. The window runs from the lower-read cycle to the cycle before the upper-read cycle. A read returns the count as it stands in the cycle of the access.
- R5: If the count carries from the lower half into the upper half at any clock edge that closes a cycle in the window, the status after the upper read is 0. A carry at the end of the upper-read cycle itself does not invalidate the pair.
- R6: A one-cycle pulse on the trap input in any cycle of the window makes the status after the upper read 0. A pulse in the upper-read cycle does not.
- R7: An upper read with no lower read since reset, or since the last upper read, sets the status to 0.
- R8: Every lower read restarts tracking and clears the status to 0.
- R9: Control reads, control writes and reads of unmapped addresses leave the status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current access (combinational) |
| trap_taken | input | 1 | One-cycle pulse when the core enters an interrupt or exception |

## Verification
The bench uses a reduced half width, so the lower half wraps within a few hundred cycles. This lets it place read pairs exactly around the carry edge. A tracker that samples the carry one cycle late would accept a pair started on the all-ones value. A tracker that counts the upper-read edge as part of the window would reject a pair whose carry happens just after the upper read. Traps are placed in the lower-read cycle and in the upper-read cycle. A design with an off-by-one window would either miss the first or reject on the second. Repeated upper reads, a fresh lower read after a good pair, and control accesses check the cases where a sloppy tracker would leave a stale 1 standing or clear a good one.

// File: rtl/snap_pkg.sv
package snap_pkg;

    localparam int BUS_W     = 32;
    localparam int VALID_BIT = 31;
    localparam int EN_BIT    = 0;

    typedef enum logic [1:0] {
        TRK_IDLE,
        TRK_LOW_SEEN,
        TRK_PAIR_DONE
    } trk_state_e;

    typedef struct packed {
        logic lo_rd;
        logic hi_rd;
        logic ctrl_wr;
    } bus_hit_t;

    function automatic logic [BUS_W-1:0] pack_ctrl(input logic en, input logic ok);
        logic [BUS_W-1:0] w;
        w            = '0;
        w[EN_BIT]    = en;
        w[VALID_BIT] = ok;
        return w;
    endfunction

endpackage

// File: rtl/snap_counter.sv
module snap_counter #(
    parameter int HALF_W = 32,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt,
    output logic             carry
);

    assign carry = en && (&cnt[HALF_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (en) cnt <= cnt + 1'b1;
    end

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        en |=> cnt == $past(cnt) + 1'b1);

    assert_count_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));

endmodule

// File: rtl/snap_tracker.sv
module snap_tracker
    import snap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lo_rd,
    input  logic hi_rd,
    input  logic carry,
    input  logic trap,
    output logic pair_ok
);

    trk_state_e state;
    logic       dirty;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TRK_IDLE;
            dirty   <= 1'b0;
            pair_ok <= 1'b0;
        end else if (lo_rd) begin
            state   <= TRK_LOW_SEEN;
            dirty   <= carry | trap;
            pair_ok <= 1'b0;
        end else if (hi_rd) begin
            if (state == TRK_LOW_SEEN) begin
                state   <= TRK_PAIR_DONE;
                pair_ok <= !dirty;
            end else begin
                state   <= TRK_IDLE;
                pair_ok <= 1'b0;
            end
        end else if (state == TRK_LOW_SEEN && (carry || trap)) begin
            dirty <= 1'b1;
        end
    end

    assert_low_clears_R8: assert property (@(posedge clk) disable iff (rst)
        lo_rd |=> !pair_ok);

    assert_orphan_high_R7: assert property (@(posedge clk) disable iff (rst)
        (hi_rd && !lo_rd && state != TRK_LOW_SEEN) |=> !pair_ok);

    assert_dirty_rejects_R5: assert property (@(posedge clk) disable iff (rst)
        (hi_rd && !lo_rd && state == TRK_LOW_SEEN && dirty) |=> !pair_ok);

    assert_valid_source_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pair_ok) |-> $past(hi_rd));

    assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!lo_rd && !hi_rd) |=> $stable(pair_ok));

endmodule

// File: rtl/snap_regs.sv
module snap_regs
    import snap_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int HALF_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h103,
    parameter logic [ADDR_W-1:0] LO_ADDR   = 'h104,
    parameter logic [ADDR_W-1:0] HI_ADDR   = 'h105,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en_bit,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              pair_ok,
    output bus_hit_t          hit,
    output logic              enable,
    output logic [BUS_W-1:0]  rdata
);

    always_comb begin
        hit         = '0;
        hit.lo_rd   = bus_en && !bus_we && bus_addr == LO_ADDR;
        hit.hi_rd   = bus_en && !bus_we && bus_addr == HI_ADDR;
        hit.ctrl_wr = bus_en &&  bus_we && bus_addr == CTRL_ADDR;
    end

    always_ff @(posedge clk) begin
        if (rst) enable <= 1'b0;
        else if (hit.ctrl_wr) enable <= wr_en_bit;
    end

    always_comb begin
        rdata = '0;
        if (bus_en && !bus_we) begin
            if (bus_addr == CTRL_ADDR) rdata = pack_ctrl(enable, pair_ok);
            else if (bus_addr == LO_ADDR) rdata = BUS_W'(cnt[HALF_W-1:0]);
            else if (bus_addr == HI_ADDR) rdata = BUS_W'(cnt[CNT_W-1:HALF_W]);
        end
    end

    assert_enable_load_R3: assert property (@(posedge clk) disable iff (rst)
        hit.ctrl_wr |=> enable == $past(wr_en_bit));

    assert_enable_keep_R3: assert property (@(posedge clk) disable iff (rst)
        !hit.ctrl_wr |=> $stable(enable));

endmodule

// File: rtl/snapshot_counter64.sv
module snapshot_counter64
    import snap_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int HALF_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h103,
    parameter logic [ADDR_W-1:0] LO_ADDR   = 'h104,
    parameter logic [ADDR_W-1:0] HI_ADDR   = 'h105
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              trap_taken
);

    localparam int CNT_W = 2 * HALF_W;

    bus_hit_t         hit;
    logic             enable;
    logic [CNT_W-1:0] cnt;
    logic             carry;
    logic             pair_ok;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata[31:1];

    snap_regs #(
        .ADDR_W(ADDR_W), .HALF_W(HALF_W),
        .CTRL_ADDR(CTRL_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
    ) regs_i (
        .clk(clk), .rst(rst),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .wr_en_bit(bus_wdata[EN_BIT]),
        .cnt(cnt), .pair_ok(pair_ok),
        .hit(hit), .enable(enable), .rdata(bus_rdata)
    );

    snap_counter #(.HALF_W(HALF_W)) ctr_i (
        .clk(clk), .rst(rst), .en(enable), .cnt(cnt), .carry(carry)
    );

    snap_tracker trk_i (
        .clk(clk), .rst(rst),
        .lo_rd(hit.lo_rd), .hi_rd(hit.hi_rd),
        .carry(carry), .trap(trap_taken),
        .pair_ok(pair_ok)
    );

    assert_one_hit_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit.lo_rd, hit.hi_rd, hit.ctrl_wr}));

endmodule

// File: tb/snapshot_counter64_tb_top.sv
module snapshot_counter64_tb_top;

    localparam int HW = 8;
    localparam logic [11:0] A_CTRL = 12'h103;
    localparam logic [11:0] A_LO   = 12'h104;
    localparam logic [11:0] A_HI   = 12'h105;
    localparam logic [11:0] A_NONE = 12'h106;

    // columns: lower value at the lower read, idle cycles in between,
    // trap cycle (0 = lower-read cycle, gap+1 = upper-read cycle, -1 = none),
    // expected status bit
    localparam int NV = 8;
    localparam int VEC [NV][4] = '{
        '{ 10, 0, -1, 1},
        '{ 10, 3,  2, 0},
        '{255, 0, -1, 0},
        '{253, 1, -1, 1},
        '{253, 2, -1, 0},
        '{ 40, 2,  3, 1},
        '{ 40, 5,  0, 0},
        '{100, 20, -1, 1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        trap_taken = 1'b0;

    int checks = 0;
    int fails  = 0;

    logic [2*HW-1:0] ref_cnt;
    logic            ref_en;

    always #5 clk = ~clk;

    snapshot_counter64 #(.ADDR_W(12), .HALF_W(HW)) dut_i (
        .clk(clk), .rst(rst),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trap_taken(trap_taken)
    );

    // requirement model of the count and its enable
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_cnt <= '0;
            ref_en  <= 1'b0;
        end else begin
            if (ref_en) ref_cnt <= ref_cnt + 1'b1;
            if (bus_en && bus_we && bus_addr == A_CTRL) ref_en <= bus_wdata[0];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic bus_op(input logic we, input logic [11:0] a, input logic [31:0] wd,
                          input logic tr, output logic [31:0] rd);
        bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd; trap_taken = tr;
        #1 rd = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; trap_taken = 1'b0;
    endtask

    task automatic idle_cycle(input logic tr);
        trap_taken = tr;
        @(negedge clk);
        trap_taken = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd, a, b;
        logic [HW-1:0] exp_hi;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_op(0, A_CTRL, 0, 0, rd); check("R1 ctrl after reset", rd, 32'h0);
        bus_op(0, A_LO,   0, 0, rd); check("R1 lower after reset", rd, 32'h0);
        bus_op(0, A_HI,   0, 0, rd); check("R1 upper after reset", rd, 32'h0);
        // R2 unmapped address
        bus_op(0, A_NONE, 0, 0, rd); check("R2 unmapped read", rd, 32'h0);

        // R3 enable and step
        bus_op(1, A_CTRL, 32'h1, 0, rd);
        bus_op(0, A_CTRL, 0, 0, rd); check("R3 enable bit", {31'b0, rd[0]}, 32'h1);
        bus_op(0, A_LO, 0, 0, a);
        bus_op(0, A_LO, 0, 0, b);
        check("R3 step by one", b - a, 32'h1);
        check("R3 lower matches model", b, 32'(ref_cnt[HW-1:0]) - 1);

        // R4 R5 R6 vector table
        for (int v = 0; v < NV; v++) begin
            while (ref_cnt[HW-1:0] != HW'(VEC[v][0])) @(negedge clk);
            bus_op(0, A_LO, 0, VEC[v][2] == 0, rd);
            check($sformatf("R4 vector %0d lower", v), rd, 32'(VEC[v][0]));
            for (int k = 1; k <= VEC[v][1]; k++) idle_cycle(VEC[v][2] == k);
            exp_hi = ref_cnt[2*HW-1:HW];
            bus_op(0, A_HI, 0, VEC[v][2] == VEC[v][1] + 1, rd);
            check($sformatf("R4 vector %0d upper", v), rd, 32'(exp_hi));
            bus_op(0, A_CTRL, 0, 0, rd);
            check($sformatf("R4/R5/R6 vector %0d status", v), {31'b0, rd[31]}, 32'(VEC[v][3]));
        end

        // R7 repeated upper read
        bus_op(0, A_LO, 0, 0, rd);
        bus_op(0, A_HI, 0, 0, rd);
        bus_op(0, A_CTRL, 0, 0, rd); check("R7 setup pair good", {31'b0, rd[31]}, 32'h1);
        bus_op(0, A_HI, 0, 0, rd);
        bus_op(0, A_CTRL, 0, 0, rd); check("R7 second upper read", {31'b0, rd[31]}, 32'h0);

        // R8 lower read clears a good status
        bus_op(0, A_LO, 0, 0, rd);
        bus_op(0, A_HI, 0, 0, rd);
        bus_op(0, A_CTRL, 0, 0, rd); check("R8 setup pair good", {31'b0, rd[31]}, 32'h1);
        bus_op(0, A_LO, 0, 0, rd);
        bus_op(0, A_CTRL, 0, 0, rd); check("R8 cleared by lower read", {31'b0, rd[31]}, 32'h0);

        // R9 control accesses keep status
        bus_op(0, A_HI, 0, 0, rd);
        bus_op(1, A_CTRL, 32'h1, 0, rd);
        bus_op(0, A_NONE, 0, 0, rd);
        bus_op(0, A_CTRL, 0, 0, rd); check("R9 status kept", rd, 32'h8000_0001);

        // R3 disable holds the count
        bus_op(1, A_CTRL, 32'h0, 0, rd);
        bus_op(0, A_LO, 0, 0, a);
        repeat (3) idle_cycle(1'b0);
        bus_op(0, A_LO, 0, 0, b);
        check("R3 hold when disabled", b, a);

        // R1 reset mid-run
        bus_op(1, A_CTRL, 32'h1, 0, rd);
        bus_op(0, A_LO, 0, 0, rd);
        bus_op(0, A_HI, 0, 0, rd);
        repeat (5) idle_cycle(1'b0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        bus_op(0, A_CTRL, 0, 0, rd); check("R1 ctrl after second reset", rd, 32'h0);
        bus_op(0, A_HI, 0, 0, rd);   check("R1 upper after second reset", rd, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule